// File: doc/BRIEF.md
# Selectable-Architecture Three-Tap FIR Filter

This block filters a stream of unsigned samples with a three-coefficient finite impulse response, producing y(n) = a·x(n) + b·x(n−1) + c·x(n−2) at full precision. It sits in a pixel or sample datapath and accepts one sample per clock whenever the upstream stage raises its valid strobe. It pairs each result with a valid strobe of its own. The three coefficients are ordinary input ports. They are meant to stay constant while a stream is in flight, and a new set is applied together with a reset.

A synthesis parameter chooses the internal architecture, trading register count and latency against the longest combinational path. The first is a plain direct form with a two-sample delay line. The second is a direct form cut by one rank of registers across all forward paths. The third is a transposed form in which the new sample reaches all three multipliers at once and partial sums travel through registers. All three give the same output sequence, apart from a one-cycle offset in the cut variant.

Top module: `fir3_tap`

## Requirements
- R1: Samples are DW-bit unsigned (default 8), coefficients are CW-bit two's-complement signed (default 8), and each result equals coef_a·x(n) + coef_b·x(n−1) + coef_c·x(n−2), where x(n−1) and x(n−2) are the two previously accepted samples.
- R2: Parameter ARCH selects the structure: 0 is plain direct form, 1 is direct form with a register cut after the multipliers, and 2 is transposed broadcast form.
- R3: For ARCH 0 and 2, the result of a sample accepted at clock edge k is on out_y after edge k. For ARCH 1 it appears after edge k+1.
- R4: out_valid is in_valid delayed by the same latency as R3.
- R5: A cycle with in_valid low accepts nothing and shifts no history, so gaps in the input stream do not alter the result sequence.
- R6: out_y holds its previous value in any cycle where out_valid is low.
- R7: out_y is OW-bit signed (default 18). It is exact at the extremes: 255 with all coefficients −128 gives −97920, and 255 with all coefficients 127 gives 97155.
- R8: A synchronous active-high reset clears the history, the partial sums, out_y and out_valid to zero, so the first results after reset treat earlier samples as zero.
- R9: A new sample is accepted on every clock that in_valid is high, including back-to-back runs. In ARCH 1 the second-stage adder completes one sample while the next is captured.
- R10: With the same inputs, all three architectures give identical result sequences once their latency is taken into account.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_x | input | DW | Unsigned input sample |
| coef_a | input | CW | Signed weight of the current sample |
| coef_b | input | CW | Signed weight of the previous sample |
| coef_c | input | CW | Signed weight of the sample before that |
| out_valid | output | 1 | Result strobe |
| out_y | output | OW | Signed full-precision result |

## Verification
The overlap that matters most is in the cut architecture: the second-stage adder retires one sample in the same cycle that the first stage captures the next. Also in that cycle, the history shifts while a partial sum is still in flight. Long back-to-back runs provoke this overlap. Randomly spaced gaps add its counterpart, a retirement with no new capture, and a capture that follows directly after an idle cycle. A behavioural queue model in the bench predicts every cycle's strobe and value for each architecture and judges the outputs, with the hold value checked during gaps.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  typedef enum int {
    ARCH_DIRECT = 0,
    ARCH_PIPE   = 1,
    ARCH_BCAST  = 2
  } fir_arch_e;

  function automatic int arch_latency(int arch);
    return (arch == ARCH_PIPE) ? 2 : 1;
  endfunction
endpackage

// File: rtl/fir3_mul.sv
module fir3_mul #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int OW = 18
) (
  input  logic [DW-1:0]        x,
  input  logic signed [CW-1:0] c,
  output logic signed [OW-1:0] p
);
  logic signed [OW-1:0] xs;
  logic signed [OW-1:0] cs;

  assign xs = $signed(OW'(x));   // zero-extend unsigned sample
  assign cs = OW'(c);            // sign-extend coefficient
  assign p  = xs * cs;
endmodule

// File: rtl/fir3_direct.sv
module fir3_direct #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int OW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_x,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [CW-1:0] coef_c,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_y
);
  logic [DW-1:0]        hist1, hist2;
  logic signed [OW-1:0] prod_a, prod_b, prod_c;

  fir3_mul #(.DW(DW), .CW(CW), .OW(OW)) u_mul_a (.x(in_x),  .c(coef_a), .p(prod_a));
  fir3_mul #(.DW(DW), .CW(CW), .OW(OW)) u_mul_b (.x(hist1), .c(coef_b), .p(prod_b));
  fir3_mul #(.DW(DW), .CW(CW), .OW(OW)) u_mul_c (.x(hist2), .c(coef_c), .p(prod_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist1     <= '0;
      hist2     <= '0;
      out_y     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        hist1 <= in_x;
        hist2 <= hist1;
        out_y <= prod_a + prod_b + prod_c;   // one multiplier plus two adders
      end
    end
  end
endmodule

// File: rtl/fir3_pipe.sv
module fir3_pipe #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int OW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_x,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [CW-1:0] coef_c,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_y
);
  logic [DW-1:0]        hist1, hist2;
  logic signed [OW-1:0] prod_a, prod_b, prod_c;
  logic signed [OW-1:0] cut_a, cut_bc;
  logic                 cut_v;

  fir3_mul #(.DW(DW), .CW(CW), .OW(OW)) u_mul_a (.x(in_x),  .c(coef_a), .p(prod_a));
  fir3_mul #(.DW(DW), .CW(CW), .OW(OW)) u_mul_b (.x(hist1), .c(coef_b), .p(prod_b));
  fir3_mul #(.DW(DW), .CW(CW), .OW(OW)) u_mul_c (.x(hist2), .c(coef_c), .p(prod_c));

  // Cut stage: every forward path gets exactly one register.
  always_ff @(posedge clk) begin
    if (rst) begin
      hist1  <= '0;
      hist2  <= '0;
      cut_a  <= '0;
      cut_bc <= '0;
      cut_v  <= 1'b0;
    end else begin
      cut_v <= in_valid;
      if (in_valid) begin
        hist1  <= in_x;
        hist2  <= hist1;
        cut_a  <= prod_a;
        cut_bc <= prod_b + prod_c;
      end
    end
  end

  // Final adder retires the earlier sample while the next is captured.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_y     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= cut_v;
      if (cut_v) out_y <= cut_a + cut_bc;
    end
  end
endmodule

// File: rtl/fir3_bcast.sv
module fir3_bcast #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int OW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_x,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [CW-1:0] coef_c,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_y
);
  logic signed [OW-1:0] prod_a, prod_b, prod_c;
  logic signed [OW-1:0] psum1, psum2;

  // The sample is broadcast to all three multipliers.
  fir3_mul #(.DW(DW), .CW(CW), .OW(OW)) u_mul_a (.x(in_x), .c(coef_a), .p(prod_a));
  fir3_mul #(.DW(DW), .CW(CW), .OW(OW)) u_mul_b (.x(in_x), .c(coef_b), .p(prod_b));
  fir3_mul #(.DW(DW), .CW(CW), .OW(OW)) u_mul_c (.x(in_x), .c(coef_c), .p(prod_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      psum1     <= '0;
      psum2     <= '0;
      out_y     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_y <= prod_a + psum1;
        psum1 <= prod_b + psum2;
        psum2 <= prod_c;
      end
    end
  end
endmodule

// File: rtl/fir3_tap.sv
module fir3_tap
  import fir3_pkg::*;
#(
  parameter int ARCH = 0,
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int OW   = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_x,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [CW-1:0] coef_c,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_y
);
  generate
    if (ARCH == ARCH_PIPE) begin : g_pipe
      fir3_pipe #(.DW(DW), .CW(CW), .OW(OW)) u_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
        .out_valid(out_valid), .out_y(out_y));
    end else if (ARCH == ARCH_BCAST) begin : g_bcast
      fir3_bcast #(.DW(DW), .CW(CW), .OW(OW)) u_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
        .out_valid(out_valid), .out_y(out_y));
    end else begin : g_direct
      fir3_direct #(.DW(DW), .CW(CW), .OW(OW)) u_core (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
        .out_valid(out_valid), .out_y(out_y));
    end
  endgenerate
endmodule

// File: rtl/fir3_checks.sv
module fir3_checks
  import fir3_pkg::*;
#(
  parameter int ARCH = 0,
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int OW   = 18
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_y
);
  localparam int LAT   = arch_latency(ARCH);
  localparam int LIMIT = ((2**DW) - 1) * (2**(CW-1)) * 3;

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  generate
    if (LAT == 2) begin : g_lat2
      p_valid_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));
    end else begin : g_lat1
      p_valid_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) |-> (out_valid == $past(in_valid)));
    end
  endgenerate

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && !out_valid) |-> $stable(out_y));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(out_y) >= -LIMIT) && (int'(out_y) <= LIMIT));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_y == '0));
endmodule

bind fir3_tap fir3_checks #(.ARCH(ARCH), .DW(DW), .CW(CW), .OW(OW)) u_checks (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_y(out_y));

// File: tb/fir3_tap_bench.sv
module fir3_tap_bench;
  localparam int PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int OW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_x = '0;
  logic signed [CW-1:0] ca = '0, cb = '0, cc = '0;
  logic ov_d, ov_p, ov_b;
  logic signed [OW-1:0] y_d, y_p, y_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int hx1, hx2, ey1, ey2;
  bit ev1, ev2;

  always #(PERIOD/2) clk = ~clk;

  // R2: one instance per architecture value
  fir3_tap #(.ARCH(0), .DW(DW), .CW(CW), .OW(OW)) u_fir3_tap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .coef_a(ca), .coef_b(cb), .coef_c(cc), .out_valid(ov_d), .out_y(y_d));
  fir3_tap #(.ARCH(1), .DW(DW), .CW(CW), .OW(OW)) u_fir3_tap_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .coef_a(ca), .coef_b(cb), .coef_c(cc), .out_valid(ov_p), .out_y(y_p));
  fir3_tap #(.ARCH(2), .DW(DW), .CW(CW), .OW(OW)) u_fir3_tap_bcast (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .coef_a(ca), .coef_b(cb), .coef_c(cc), .out_valid(ov_b), .out_y(y_b));

  task automatic chk(string req, string who, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, who, act, exp);
    end
  endtask

  // Called at a falling edge: judge outputs, then drive the next input.
  task automatic step(bit v, int x, string req);
    chk("R4", "direct valid", int'(ov_d), int'(ev1));
    chk("R4", "bcast valid",  int'(ov_b), int'(ev1));
    chk("R4", "pipe valid",   int'(ov_p), int'(ev2));
    chk(req, "direct y (R3)", int'(y_d), ey1);
    chk(req, "bcast y (R3)",  int'(y_b), ey1);
    chk(req, "pipe y (R3)",   int'(y_p), ey2);
    chk("R10", "direct vs bcast", int'(y_b), int'(y_d));
    ev2 = ev1;
    ey2 = ey1;
    in_valid = v;
    in_x = DW'(x);
    ev1 = v;
    if (v) begin
      ey1 = int'(ca) * x + int'(cb) * hx1 + int'(cc) * hx2;  // R1
      hx2 = hx1;
      hx1 = x;
    end
    @(negedge clk);
  endtask

  task automatic do_reset(int a, int b, int c);
    rst = 1'b1;
    in_valid = 1'b0;
    ca = CW'(a); cb = CW'(b); cc = CW'(c);
    @(negedge clk);
    @(negedge clk);
    // R8: cleared while reset is held
    chk("R8", "direct y in reset", int'(y_d), 0);
    chk("R8", "pipe y in reset",   int'(y_p), 0);
    chk("R8", "bcast y in reset",  int'(y_b), 0);
    chk("R8", "valid in reset", int'({ov_d, ov_p, ov_b}), 0);
    rst = 1'b0;
    hx1 = 0; hx2 = 0; ey1 = 0; ey2 = 0; ev1 = 0; ev2 = 0;
  endtask

  initial begin
    @(negedge clk);
    // R8: history treated as zero after reset
    do_reset(3, -2, 5);
    step(1, 10, "R8");
    step(1, 20, "R8");
    step(1, 7, "R1");
    step(0, 0, "R1");
    step(0, 0, "R1");

    // R9: back-to-back run, random data
    do_reset(-7, 19, 100);
    for (int i = 0; i < 300; i++) step(1, $urandom_range(0, 255), "R9");
    step(0, 0, "R9");
    step(0, 0, "R9");

    // R5 and R6: random gaps, history frozen and outputs held
    do_reset(-128, 127, -33);
    for (int i = 0; i < 400; i++)
      step(($urandom_range(0, 1) == 1), $urandom_range(0, 255), "R5");
    for (int i = 0; i < 6; i++) step(0, 77, "R6");

    // R7: extremes
    do_reset(-128, -128, -128);
    for (int i = 0; i < 5; i++) step(1, 255, "R7");
    step(0, 0, "R7");
    step(0, 0, "R7");
    chk("R7", "direct min", int'(y_d), -97920);
    chk("R7", "pipe min",   int'(y_p), -97920);
    do_reset(127, 127, 127);
    for (int i = 0; i < 5; i++) step(1, 255, "R7");
    step(0, 0, "R7");
    step(0, 0, "R7");
    chk("R7", "bcast max", int'(y_b), 97155);
    chk("R7", "pipe max",  int'(y_p), 97155);

    // R10: mixed random coefficients and stream
    for (int k = 0; k < 4; k++) begin
      do_reset($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
               $urandom_range(0, 255) - 128);
      for (int i = 0; i < 150; i++)
        step(($urandom_range(0, 3) != 0), $urandom_range(0, 255), "R10");
      step(0, 0, "R10");
      step(0, 0, "R10");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule